// File: doc/BRIEF.md
# Publish/Subscribe Event Channel Router

This block joins single-cycle event pulses from peripheral sources to peripheral task inputs through a bank of shared trigger channels. Each event source has a publish setting and each task input has a subscribe setting. A setting holds an enable flag and an 8-bit channel number. An event whose publish setting is enabled drives its channel. Every task whose subscribe setting is enabled and names that channel then fires.

Any number of sources and tasks may share one channel, so the connections form a many-to-many mesh. Sources that hit the same channel in the same cycle merge into one channel pulse. A channel carries traffic only while its global enable bit is 1. That bit comes from a separate controller. Each channel also carries a secure flag, and each peripheral carries a security attribute. A non-secure peripheral loses its connection to any channel that is currently flagged secure.

Configuration is written through a simple one-cycle write strobe. A write selects the publish or subscribe bank and an entry number, and carries the flag and the channel number. Routing is registered once.

Top module: `event_router`

## Requirements
- R1: After reset every publish and subscribe setting is disabled and points at channel 0, and `tsk_out` is 0. With all channels enabled and all events pulsing, no task fires until a setting is enabled.
- R2: A connection takes effect only while its enable flag is 1. A write with `cfg_en`=0 disconnects the entry, and a write with `cfg_en`=1 connects it. `cfg_is_sub`=0 selects the publish bank and 1 selects the subscribe bank.
- R3: One event on a channel triggers every task subscribed to that channel in the same cycle.
- R4: Two or more events published onto one channel in the same cycle merge into one pulse, so each subscriber fires for exactly one cycle. Each of those events alone also triggers the subscribers.
- R5: A channel pulse reaches subscribers only while `chan_en` bit c is 1 in the event's cycle. Otherwise the event is dropped.
- R6: A channel number of 32 or more (beyond N_CH-1) is unconnected. A publish setting with such a number drives no channel, and a subscribe setting with such a number never fires.
- R7: An event at `evt_in` in cycle t produces its task pulse on `tsk_out` in cycle t+1 and not earlier.
- R8: While `chan_secure` bit c is 1, a publisher with `evt_secure`=0 or a subscriber with `tsk_secure`=0 is masked off from channel c. A peripheral whose secure bit is 1 may use any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_sub | input | 1 | 0 selects the publish bank, 1 selects the subscribe bank |
| cfg_addr | input | AW | Entry number within the selected bank |
| cfg_en | input | 1 | Enable flag to store |
| cfg_chan | input | 8 | Channel number to store |
| chan_en | input | N_CH | Global per-channel enable |
| chan_secure | input | N_CH | Per-channel secure flag |
| evt_in | input | N_EVT | Event pulses from the sources |
| evt_secure | input | N_EVT | Security attribute of each source |
| tsk_secure | input | N_TSK | Security attribute of each task owner |
| tsk_out | output | N_TSK | Registered task pulses |

## Verification
The assertions assume that `chan_en`, `chan_secure` and the secure attributes are valid levels in the cycle an event is presented. They also assume `evt_in` is sampled only at rising edges. The bench changes every input on the falling edge and holds it through the next rising edge, so each routing decision sees one stable set of gates. Sweeps confine channel numbers to a few low channels plus out-of-range values, so that collisions, merges and unconnected indices occur often.

// File: rtl/router_pkg.sv
package router_pkg;
    localparam int CH_IDX_W = 8;

    typedef struct packed {
        logic                en;
        logic [CH_IDX_W-1:0] idx;
    } route_cfg_t;
endpackage

// File: rtl/route_cfg_bank.sv
module route_cfg_bank
    import router_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic                wr_en,
    input  logic [CH_IDX_W-1:0] wr_idx,
    output route_cfg_t [N-1:0]  cfg_o
);
    generate
        for (genvar k = 0; k < N; k++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_o[k] <= '0;
                end else if (we && (int'(addr) == k)) begin
                    cfg_o[k].en  <= wr_en;
                    cfg_o[k].idx <= wr_idx;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/publish_merge.sv
module publish_merge
    import router_pkg::*;
#(
    parameter int N_EVT = 4,
    parameter int N_CH  = 32
) (
    input  logic [N_EVT-1:0]      evt,
    input  logic [N_EVT-1:0]      evt_sec,
    input  route_cfg_t [N_EVT-1:0] cfg,
    input  logic [N_CH-1:0]       chan_sec,
    input  logic [N_CH-1:0]       chan_en,
    output logic [N_CH-1:0]       chan_hit
);
    always_comb begin
        chan_hit = '0;
        for (int c = 0; c < N_CH; c++) begin
            for (int i = 0; i < N_EVT; i++) begin
                if (evt[i] && cfg[i].en && (cfg[i].idx == CH_IDX_W'(c))
                    && (evt_sec[i] || !chan_sec[c])) begin
                    chan_hit[c] = 1'b1;
                end
            end
        end
        chan_hit = chan_hit & chan_en;
    end
endmodule

// File: rtl/subscribe_fanout.sv
module subscribe_fanout
    import router_pkg::*;
#(
    parameter int N_TSK = 4,
    parameter int N_CH  = 32
) (
    input  logic [N_CH-1:0]        chan_hit,
    input  logic [N_CH-1:0]        chan_sec,
    input  logic [N_TSK-1:0]       tsk_sec,
    input  route_cfg_t [N_TSK-1:0] cfg,
    output logic [N_TSK-1:0]       tsk_next
);
    always_comb begin
        tsk_next = '0;
        for (int j = 0; j < N_TSK; j++) begin
            for (int c = 0; c < N_CH; c++) begin
                if (cfg[j].en && (cfg[j].idx == CH_IDX_W'(c)) && chan_hit[c]
                    && (tsk_sec[j] || !chan_sec[c])) begin
                    tsk_next[j] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/event_router.sv
module event_router
    import router_pkg::*;
#(
    parameter int N_EVT = 4,
    parameter int N_TSK = 4,
    parameter int N_CH  = 32,
    localparam int NMAX = (N_EVT > N_TSK) ? N_EVT : N_TSK,
    localparam int AW   = (NMAX > 1) ? $clog2(NMAX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_is_sub,
    input  logic [AW-1:0]       cfg_addr,
    input  logic                cfg_en,
    input  logic [CH_IDX_W-1:0] cfg_chan,
    input  logic [N_CH-1:0]     chan_en,
    input  logic [N_CH-1:0]     chan_secure,
    input  logic [N_EVT-1:0]    evt_in,
    input  logic [N_EVT-1:0]    evt_secure,
    input  logic [N_TSK-1:0]    tsk_secure,
    output logic [N_TSK-1:0]    tsk_out
);
    route_cfg_t [N_EVT-1:0] pub_cfg;
    route_cfg_t [N_TSK-1:0] sub_cfg;
    logic [N_CH-1:0]        chan_hit;
    logic [N_TSK-1:0]       tsk_next;

    route_cfg_bank #(.N(N_EVT), .AW(AW)) u_pub_bank (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we && !cfg_is_sub), .addr(cfg_addr),
        .wr_en(cfg_en), .wr_idx(cfg_chan), .cfg_o(pub_cfg)
    );

    route_cfg_bank #(.N(N_TSK), .AW(AW)) u_sub_bank (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we && cfg_is_sub), .addr(cfg_addr),
        .wr_en(cfg_en), .wr_idx(cfg_chan), .cfg_o(sub_cfg)
    );

    publish_merge #(.N_EVT(N_EVT), .N_CH(N_CH)) u_merge (
        .evt(evt_in), .evt_sec(evt_secure), .cfg(pub_cfg),
        .chan_sec(chan_secure), .chan_en(chan_en), .chan_hit(chan_hit)
    );

    subscribe_fanout #(.N_TSK(N_TSK), .N_CH(N_CH)) u_fanout (
        .chan_hit(chan_hit), .chan_sec(chan_secure), .tsk_sec(tsk_secure),
        .cfg(sub_cfg), .tsk_next(tsk_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tsk_out <= '0;
        else        tsk_out <= tsk_next;
    end
endmodule

// File: rtl/event_router_chk.sv
module event_router_chk #(
    parameter int N_EVT = 4,
    parameter int N_TSK = 4,
    parameter int N_CH  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_CH-1:0]  chan_en,
    input logic [N_CH-1:0]  chan_secure,
    input logic [N_EVT-1:0] evt_in,
    input logic [N_EVT-1:0] evt_secure,
    input logic [N_TSK-1:0] tsk_secure,
    input logic [N_TSK-1:0] tsk_out
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (tsk_out == '0));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|tsk_out) |-> $past(|evt_in));

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|tsk_out) |-> $past(|chan_en));

    p_pub_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~|evt_secure) && (&chan_secure)) |=> (tsk_out == '0));

    p_sub_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~|tsk_secure) && (&chan_secure)) |=> (tsk_out == '0));
endmodule

bind event_router event_router_chk #(.N_EVT(N_EVT), .N_TSK(N_TSK), .N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_secure(chan_secure),
    .evt_in(evt_in), .evt_secure(evt_secure), .tsk_secure(tsk_secure),
    .tsk_out(tsk_out)
);

// File: tb/event_router_tb.sv
module event_router_tb;
    localparam int CLK_NS = 10;
    localparam int NE = 4;
    localparam int NT = 4;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_is_sub = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic          cfg_en = 1'b0;
    logic [7:0]    cfg_chan = '0;
    logic [NC-1:0] chan_en = '0;
    logic [NC-1:0] chan_secure = '0;
    logic [NE-1:0] evt_in = '0;
    logic [NE-1:0] evt_secure = '0;
    logic [NT-1:0] tsk_secure = '0;
    logic [NT-1:0] tsk_out;

    int checks = 0;
    int errors = 0;

    logic       m_pub_en [NE];
    logic [7:0] m_pub_ch [NE];
    logic       m_sub_en [NT];
    logic [7:0] m_sub_ch [NT];

    event_router #(.N_EVT(NE), .N_TSK(NT), .N_CH(NC)) u_dut (.*);

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(string tag, logic [NT-1:0] act, logic [NT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tsk_out=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] model();
        logic [NT-1:0] r = '0;
        for (int j = 0; j < NT; j++) begin
            int c = int'(m_sub_ch[j]);
            if (m_sub_en[j] && c < NC && chan_en[c] && (tsk_secure[j] || !chan_secure[c])) begin
                for (int i = 0; i < NE; i++)
                    if (evt_in[i] && m_pub_en[i] && int'(m_pub_ch[i]) == c
                        && (evt_secure[i] || !chan_secure[c])) r[j] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic wr(logic sub, int a, logic en, logic [7:0] ch);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_sub = sub; cfg_addr = 2'(a); cfg_en = en; cfg_chan = ch;
        if (sub) begin m_sub_en[a] = en; m_sub_ch[a] = ch; end
        else     begin m_pub_en[a] = en; m_pub_ch[a] = ch; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive events at a falling edge; result appears after the next rising edge
    task automatic fire(string tag, logic [NE-1:0] ev, logic [NT-1:0] exp);
        logic [NT-1:0] mexp;
        @(negedge clk);
        evt_in = ev;
        mexp = model();
        chk({tag, " model"}, mexp, exp);
        @(negedge clk);
        chk(tag, tsk_out, exp);
        evt_in = '0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: tsk_out=%b expected completion", tsk_out);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < NE; i++) begin m_pub_en[i] = 0; m_pub_ch[i] = 0; end
        for (int j = 0; j < NT; j++) begin m_sub_en[j] = 0; m_sub_ch[j] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 reset", tsk_out, '0);
        rst_n = 1'b1;
        chan_en = '1;
        fire("R1 disabled after reset", 4'hF, 4'h0);

        // R2: enable flag
        wr(0, 0, 1, 8'd3);
        wr(1, 0, 0, 8'd3);
        fire("R2 sub flag off", 4'h1, 4'h0);
        wr(1, 0, 1, 8'd3);
        fire("R2 sub flag on", 4'h1, 4'h1);
        wr(0, 0, 0, 8'd3);
        fire("R2 pub flag off", 4'h1, 4'h0);
        wr(0, 0, 1, 8'd3);

        // R3: fan-out
        for (int j = 1; j < NT; j++) wr(1, j, 1, 8'd3);
        fire("R3 fan-out", 4'h1, 4'hF);

        // R7: latency, output still low before the capturing edge
        @(negedge clk);
        evt_in = 4'h1;
        #1 chk("R7 not before edge", tsk_out, 4'h0);
        @(posedge clk); #1;
        chk("R7 one cycle later", tsk_out, 4'hF);
        @(negedge clk);
        evt_in = '0;

        // R4: merge
        wr(0, 1, 1, 8'd3);
        fire("R4 merged", 4'h3, 4'hF);
        @(negedge clk);
        chk("R4 single pulse", tsk_out, 4'h0);
        fire("R4 second event alone", 4'h2, 4'hF);

        // R5: global gate
        chan_en[3] = 1'b0;
        fire("R5 channel disabled", 4'h3, 4'h0);
        chan_en[3] = 1'b1;

        // R6: out-of-range channels
        wr(0, 2, 1, 8'd40);
        wr(1, 3, 1, 8'd40);
        fire("R6 index 40", 4'h4, 4'h0);
        wr(0, 2, 1, 8'd32);
        wr(1, 3, 1, 8'd32);
        fire("R6 index 32", 4'h4, 4'h0);
        wr(0, 2, 1, 8'd31);
        wr(1, 3, 1, 8'd31);
        fire("R6 index 31 live", 4'h4, 4'h8);

        // R8: security
        chan_secure[3] = 1'b1;
        tsk_secure = 4'b0101;
        fire("R8 ns publisher masked", 4'h1, 4'h0);
        evt_secure = 4'h1;
        fire("R8 secure publisher", 4'h1, 4'b0101);
        chan_secure[3] = 1'b0;
        evt_secure = '0;
        fire("R8 channel back non-secure", 4'h1, 4'h7);
        tsk_secure = '0;

        // sweep: channels 0..3 and out-of-range values, random gates
        lcg = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ch;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            ch = (lcg[20:18] < 3'd6) ? {6'd0, lcg[17:16]} : (lcg[19] ? 8'd32 : 8'd200);
            wr(lcg[31], int'(lcg[25:24]), lcg[23] | lcg[22], ch);
            @(negedge clk);
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            chan_en     = {28'hFFF_FFFF, lcg[3:0] | lcg[7:4]};
            chan_secure = {28'h0, lcg[11:8] & lcg[15:12]};
            evt_secure  = lcg[19:16];
            tsk_secure  = lcg[23:20];
            evt_in      = lcg[27:24];
            begin
                logic [NT-1:0] e;
                e = model();
                @(negedge clk);
                chk("R3 R4 R5 R8 sweep", tsk_out, e);
            end
            evt_in = '0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule